// File: doc/BRIEF.md
# Cache Mode Latch and Flush Sequencer

This block controls the operating mode of a small data cache and the way that cache is flushed. While hard reset is asserted, a mode pin is watched, and the block checks it again for a short window after reset is released. The block selects write-back mode only if the pin stays high for that whole window. Otherwise it falls back to write-through mode. The chosen mode then stays fixed until the next hard reset. A soft reset input never changes it.

The block keeps a two-bit coherence state for every cache line. Allocations, write hits and single-line invalidates update that state. The data array, the tag compare and the choice of victim line belong to the surrounding cache.

A flush works differently in each mode:
- In write-through mode, a flush clears every line in one clock.
- In write-back mode, a flush starts a walk over all lines in ascending order. Each modified line is handed to the bus through a request/acknowledge pair. When the last line is done, the block emits a one-clock flush-acknowledge special cycle.

Top module: `cache_flush_ctrl`

## Requirements
- R1: After hard reset deasserts, `mode_ready` is low after the first clock edge and high after the second, and it stays high. `mode_wb` reads 1 only if `mode_pin` was high at the last two edges inside reset and at the first two edges after it. Any low sample in that window gives `mode_wb` = 0.
- R2: While `mode_ready` is low, allocation, write-hit, invalidate and flush inputs have no effect on any line state.
- R3: Once `mode_ready` is high, `mode_wb` does not change until the next hard reset, whatever `mode_pin` or `soft_rst` do.
- R4: Line states are encoded Invalid=00, Shared=01, Exclusive=10, Modified=11. After hard reset every line is Invalid. `q_state` shows the state of line `q_idx` combinationally.
- R5: An allocation writes line `alloc_idx` at the next edge. In write-back mode it writes Exclusive when `alloc_wb` is 1 and Shared when it is 0. In write-through mode it always writes Shared, so `alloc_wb` is ignored.
- R6: A write hit changes an Exclusive line to Modified. It leaves a line in any other state unchanged.
- R7: `inv_valid` sets line `inv_idx` to Invalid in write-back mode. In write-through mode it is ignored.
- R8: In write-through mode, a `flush_req` sampled at an edge leaves every line Invalid after that edge. `wb_req` and `flush_ack_cycle` stay low throughout.
- R9: In write-back mode, a flush visits lines in ascending index order. For each Modified line it raises `wb_req` with that index on `wb_idx` and holds both until `wb_ack`. No request is made for a line that is not Modified. Every line is Invalid when the walk ends.
- R10: A write-back flush ends with exactly one `flush_ack_cycle` pulse, one clock wide. Counting edges after the edge that sampled `flush_req`, the pulse appears after 16 + Σ(wait edges of each write-back) edges, where a write-back's wait edges run from its first `wb_req` cycle to the edge that samples `wb_ack`. All lines are Invalid during the pulse.
- R11: While a walk is in progress (`flush_busy` high), a further `flush_req` is dropped, not queued. Allocation, write-hit and invalidate inputs are also ignored during that time.
- R12: `bus_lock` follows `lock_req` in write-through mode and is held low in write-back mode.
- R13: `soft_rst` clears every line to Invalid in write-through mode. In write-back mode it leaves both the lines and the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, synchronous, active low |
| mode_pin | input | 1 | Mode select, high requests write-back |
| soft_rst | input | 1 | Soft reset pulse, active high |
| alloc_valid | input | 1 | Allocate a line this cycle |
| alloc_idx | input | 4 | Line being allocated |
| alloc_wb | input | 1 | Per-line policy, high = write-back line |
| wr_hit_valid | input | 1 | Write hit this cycle |
| wr_hit_idx | input | 4 | Line hit by the write |
| inv_valid | input | 1 | Invalidate one line |
| inv_idx | input | 4 | Line to invalidate |
| flush_req | input | 1 | Flush request |
| wb_ack | input | 1 | Bus accepted the pending write-back |
| lock_req | input | 1 | Request for a locked bus cycle |
| q_idx | input | 4 | Line selected for state query |
| q_state | output | 2 | State of line `q_idx` |
| mode_ready | output | 1 | Mode has been settled |
| mode_wb | output | 1 | Latched mode, 1 = write-back |
| flush_busy | output | 1 | Write-back walk in progress |
| wb_req | output | 1 | Write-back request |
| wb_idx | output | 4 | Line being written back |
| flush_ack_cycle | output | 1 | Flush-acknowledge special cycle |
| bus_lock | output | 1 | Locked bus cycle indication |

## Verification
The hardest situation to reach is a write-back walk that gets a new flush request and a line update while it is stalled on the bus, because the walk only stalls when a line is Modified and only for as long as the bench holds off `wb_ack`. The stimulus first builds a mix of Shared, Exclusive and Modified lines using policy-tagged allocations and write hits. The bench then acts as the bus responder and delays each acknowledge by an amount derived from the line index. At the first write-back request it injects a fresh flush and an allocation. Afterwards it checks the request order, the edge on which the single acknowledge pulse arrives (computed from the delays), and that the injected allocation left no trace. The mode window is swept over all sixteen combinations of the four qualifying samples.

// File: rtl/cfl_pkg.sv
// Shared types of the cache mode latch and flush sequencer.
package cfl_pkg;

    // Per-line coherence state; the encoding is visible on q_state.
    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_SHR = 2'b01,
        LS_EXC = 2'b10,
        LS_MOD = 2'b11
    } line_st_e;

    // Flush walker control states.
    typedef enum logic [1:0] {
        WK_IDLE = 2'b00,
        WK_SCAN = 2'b01,
        WK_WAIT = 2'b10,
        WK_DONE = 2'b11
    } walk_st_e;

endpackage

// File: rtl/cfl_mode_latch.sv
// Mode latch.
// Shifts the mode pin through a window register while hard reset is held
// and for POST_CLKS-1 edges after release. On the POST_CLKS-th edge after
// release it settles write-back mode if every sample in the window,
// including the current one, was high, and then stops.
// Assumes: rst_n is synchronous, held for at least PRE_CLKS edges,
// PRE_CLKS >= 1 and POST_CLKS >= 1.
module cfl_mode_latch #(
    parameter int PRE_CLKS  = 2,
    parameter int POST_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_pin,
    output logic mode_ready,
    output logic mode_wb
);
    localparam int WIN   = PRE_CLKS + POST_CLKS - 1;
    localparam int CNT_W = $clog2(POST_CLKS) + 1;

    logic [WIN-1:0]   win_q;
    logic [CNT_W-1:0] post_cnt_q;

    // Sample the pin during reset and the post-release window, then freeze.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q      <= (win_q << 1) | WIN'(mode_pin);
            post_cnt_q <= '0;
            mode_ready <= 1'b0;
            mode_wb    <= 1'b0;
        end else if (!mode_ready) begin
            win_q <= (win_q << 1) | WIN'(mode_pin);
            if (post_cnt_q == CNT_W'(POST_CLKS - 1)) begin
                mode_ready <= 1'b1;
                mode_wb    <= &{win_q, mode_pin};
            end else begin
                post_cnt_q <= post_cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfl_line_array.sv
// Line-state array.
// Holds one coherence state per line in flops so that a whole-array clear
// takes one edge. Priority per line: global clear, walker invalidate,
// then (only when upd_en) allocate > write hit > invalidate input.
// Assumes: mode_wb is stable while upd_en is high.
module cfl_line_array
    import cfl_pkg::*;
#(
    parameter int LINES = 16,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_wb,
    input  logic               clear_all,
    input  logic               walk_inv,
    input  logic [IDX_W-1:0]   walk_idx,
    input  logic               upd_en,
    input  logic               alloc_valid,
    input  logic [IDX_W-1:0]   alloc_idx,
    input  logic               alloc_wb,
    input  logic               hit_valid,
    input  logic [IDX_W-1:0]   hit_idx,
    input  logic               inv_valid,
    input  logic [IDX_W-1:0]   inv_idx,
    output logic [2*LINES-1:0] st_vec
);
    line_st_e st_q [LINES];
    line_st_e alloc_st;

    // State a fresh allocation receives under the latched mode.
    always_comb alloc_st = (mode_wb && alloc_wb) ? LS_EXC : LS_SHR;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic sel_alloc, sel_hit, sel_inv, sel_walk;

        // Decode which request targets this line.
        always_comb begin
            sel_walk  = walk_inv && (walk_idx == IDX_W'(g));
            sel_alloc = upd_en && alloc_valid && (alloc_idx == IDX_W'(g));
            sel_hit   = upd_en && hit_valid && (hit_idx == IDX_W'(g));
            sel_inv   = upd_en && inv_valid && mode_wb && (inv_idx == IDX_W'(g));
        end

        // Update this line's state.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g] <= LS_INV;
            end else if (clear_all || sel_walk) begin
                st_q[g] <= LS_INV;
            end else if (sel_alloc) begin
                st_q[g] <= alloc_st;
            end else if (sel_hit) begin
                if (st_q[g] == LS_EXC) st_q[g] <= LS_MOD;
            end else if (sel_inv) begin
                st_q[g] <= LS_INV;
            end
        end

        assign st_vec[2*g +: 2] = st_q[g];
    end

endmodule

// File: rtl/cfl_flush_walker.sv
// Flush walker.
// Visits lines 0..LINES-1, one per edge. A Modified line stalls the walk
// with wb_req high until wb_ack; every visited line is invalidated. After
// the last line one cycle is spent in WK_DONE, which drives done_pulse.
// Assumes: start is only raised while busy is low; cur_mod reflects the
// line at walk_idx.
module cfl_flush_walker
    import cfl_pkg::*;
#(
    parameter int LINES = 16,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cur_mod,
    input  logic             wb_ack,
    output logic             busy,
    output logic [IDX_W-1:0] walk_idx,
    output logic             walk_inv,
    output logic             wb_req,
    output logic             done_pulse
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

    walk_st_e st_q;

    // Sequence the walk over the array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= WK_IDLE;
            walk_idx <= '0;
        end else begin
            unique case (st_q)
                WK_IDLE: if (start) begin
                    st_q     <= WK_SCAN;
                    walk_idx <= '0;
                end
                WK_SCAN: begin
                    if (cur_mod)                st_q <= WK_WAIT;
                    else if (walk_idx == LAST)  st_q <= WK_DONE;
                    else                        walk_idx <= walk_idx + 1'b1;
                end
                WK_WAIT: if (wb_ack) begin
                    if (walk_idx == LAST) begin
                        st_q <= WK_DONE;
                    end else begin
                        st_q     <= WK_SCAN;
                        walk_idx <= walk_idx + 1'b1;
                    end
                end
                WK_DONE: st_q <= WK_IDLE;
                default: st_q <= WK_IDLE;
            endcase
        end
    end

    // Decode outputs from the registered state.
    always_comb begin
        busy       = (st_q != WK_IDLE);
        wb_req     = (st_q == WK_WAIT);
        done_pulse = (st_q == WK_DONE);
        walk_inv   = ((st_q == WK_SCAN) && !cur_mod) || ((st_q == WK_WAIT) && wb_ack);
    end

endmodule

// File: rtl/cache_flush_ctrl.sv
// Cache mode latch and flush sequencer (top).
// Settles the cache mode after hard reset, keeps the line-state array and
// runs flushes: a one-edge clear in write-through mode, a write-back walk
// ending in a flush-acknowledge cycle in write-back mode.
// Assumes: synchronous active-low hard reset; the bus holds wb_ack for
// one cycle per accepted write-back.
module cache_flush_ctrl
    import cfl_pkg::*;
#(
    parameter int LINES     = 16,
    parameter int IDX_W     = $clog2(LINES),
    parameter int PRE_CLKS  = 2,
    parameter int POST_CLKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_pin,
    input  logic             soft_rst,
    input  logic             alloc_valid,
    input  logic [IDX_W-1:0] alloc_idx,
    input  logic             alloc_wb,
    input  logic             wr_hit_valid,
    input  logic [IDX_W-1:0] wr_hit_idx,
    input  logic             inv_valid,
    input  logic [IDX_W-1:0] inv_idx,
    input  logic             flush_req,
    input  logic             wb_ack,
    input  logic             lock_req,
    input  logic [IDX_W-1:0] q_idx,
    output logic [1:0]       q_state,
    output logic             mode_ready,
    output logic             mode_wb,
    output logic             flush_busy,
    output logic             wb_req,
    output logic [IDX_W-1:0] wb_idx,
    output logic             flush_ack_cycle,
    output logic             bus_lock
);
    logic [2*LINES-1:0] st_vec;
    logic               clear_all, upd_en, walk_start, walk_inv, cur_mod;
    logic [IDX_W-1:0]   walk_idx;

    cfl_mode_latch #(.PRE_CLKS(PRE_CLKS), .POST_CLKS(POST_CLKS)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_pin   (mode_pin),
        .mode_ready (mode_ready),
        .mode_wb    (mode_wb)
    );

    // Route flush and soft reset by mode; gate line updates.
    always_comb begin
        clear_all  = mode_ready && !mode_wb && (flush_req || soft_rst);
        walk_start = mode_ready && mode_wb && flush_req && !flush_busy;
        upd_en     = mode_ready && !flush_busy;
        cur_mod    = (st_vec[{walk_idx, 1'b0} +: 2] == LS_MOD);
        q_state    = st_vec[{q_idx, 1'b0} +: 2];
        bus_lock   = lock_req && !mode_wb;
        wb_idx     = walk_idx;
    end

    cfl_line_array #(.LINES(LINES), .IDX_W(IDX_W)) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_wb     (mode_wb),
        .clear_all   (clear_all),
        .walk_inv    (walk_inv),
        .walk_idx    (walk_idx),
        .upd_en      (upd_en),
        .alloc_valid (alloc_valid),
        .alloc_idx   (alloc_idx),
        .alloc_wb    (alloc_wb),
        .hit_valid   (wr_hit_valid),
        .hit_idx     (wr_hit_idx),
        .inv_valid   (inv_valid),
        .inv_idx     (inv_idx),
        .st_vec      (st_vec)
    );

    cfl_flush_walker #(.LINES(LINES), .IDX_W(IDX_W)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (walk_start),
        .cur_mod    (cur_mod),
        .wb_ack     (wb_ack),
        .busy       (flush_busy),
        .walk_idx   (walk_idx),
        .walk_inv   (walk_inv),
        .wb_req     (wb_req),
        .done_pulse (flush_ack_cycle)
    );

endmodule

// File: rtl/cfl_checker.sv
// Temporal checks for cache_flush_ctrl, bound to every instance.
module cfl_checker #(
    parameter int LINES = 16,
    parameter int IDX_W = $clog2(LINES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mode_ready,
    input logic               mode_wb,
    input logic               flush_req,
    input logic               wb_req,
    input logic               wb_ack,
    input logic [IDX_W-1:0]   wb_idx,
    input logic               flush_ack_cycle,
    input logic               bus_lock,
    input logic [2*LINES-1:0] st_vec
);
    // R1: readiness never drops outside reset
    p_ready_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ready |=> mode_ready);

    // R3: settled mode is frozen
    p_mode_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ready && $past(mode_ready)) |-> (mode_wb == $past(mode_wb)));

    // R8: write-through flush clears the array at the next edge
    p_wt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ready && !mode_wb && flush_req) |=> (st_vec == '0));

    // R8: no bus traffic from flushes in write-through mode
    p_wt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ready && !mode_wb) |-> (!wb_req && !flush_ack_cycle));

    // R9: a pending write-back holds request and index
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_idx)));

    // R10: acknowledge cycle is a single clock
    p_ack_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ack_cycle |=> !flush_ack_cycle);

    // R10: the array is empty during the acknowledge cycle
    p_ack_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ack_cycle |-> (st_vec == '0));

    // R12: no locked cycles in write-back mode
    p_no_lock_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wb |-> !bus_lock);

endmodule

bind cache_flush_ctrl cfl_checker #(.LINES(LINES), .IDX_W(IDX_W)) u_cfl_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .mode_ready      (mode_ready),
    .mode_wb         (mode_wb),
    .flush_req       (flush_req),
    .wb_req          (wb_req),
    .wb_ack          (wb_ack),
    .wb_idx          (wb_idx),
    .flush_ack_cycle (flush_ack_cycle),
    .bus_lock        (bus_lock),
    .st_vec          (st_vec)
);

// File: tb/tb_cache_flush_ctrl.sv
`timescale 1ns/100ps
module tb_cache_flush_ctrl;
    localparam int LINES = 16;

    logic       clk = 1'b0;
    logic       rst_n, mode_pin, soft_rst;
    logic       alloc_valid, alloc_wb, wr_hit_valid, inv_valid;
    logic [3:0] alloc_idx, wr_hit_idx, inv_idx, q_idx, wb_idx;
    logic       flush_req, wb_ack, lock_req;
    logic [1:0] q_state;
    logic       mode_ready, mode_wb, flush_busy, wb_req, flush_ack_cycle, bus_lock;

    int nchk = 0, nfail = 0;
    bit done = 0;
    logic [1:0] exp_st [LINES];

    always #4 clk = ~clk;

    cache_flush_ctrl dut (
        .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin), .soft_rst(soft_rst),
        .alloc_valid(alloc_valid), .alloc_idx(alloc_idx), .alloc_wb(alloc_wb),
        .wr_hit_valid(wr_hit_valid), .wr_hit_idx(wr_hit_idx),
        .inv_valid(inv_valid), .inv_idx(inv_idx), .flush_req(flush_req),
        .wb_ack(wb_ack), .lock_req(lock_req), .q_idx(q_idx), .q_state(q_state),
        .mode_ready(mode_ready), .mode_wb(mode_wb), .flush_busy(flush_busy),
        .wb_req(wb_req), .wb_idx(wb_idx), .flush_ack_cycle(flush_ack_cycle),
        .bus_lock(bus_lock)
    );

    task automatic check(string tag, int act, int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        soft_rst = 0; alloc_valid = 0; alloc_idx = 0; alloc_wb = 0;
        wr_hit_valid = 0; wr_hit_idx = 0; inv_valid = 0; inv_idx = 0;
        flush_req = 0; wb_ack = 0; lock_req = 0; q_idx = 0;
    endtask

    task automatic check_array(string tag);
        for (int i = 0; i < LINES; i++) begin
            q_idx = 4'(i);
            #0.2;
            check(tag, q_state, exp_st[i]);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < LINES; i++) exp_st[i] = 2'b00;
    endtask

    // Hard reset with the four window samples; optional poke of an
    // allocation before the mode is settled (R2).
    task automatic do_reset(bit early, bit [1:0] pre, bit [1:0] post, bit poke);
        bit exp_wb = &{pre, post};
        idle_inputs();
        rst_n = 0; mode_pin = early;
        repeat (4) step();
        mode_pin = pre[1]; step();
        mode_pin = pre[0]; step();
        rst_n = 1; mode_pin = post[1];
        if (poke) begin alloc_valid = 1; alloc_idx = 0; alloc_wb = 1; flush_req = 1; end
        step();
        check("R1 ready low after first edge", mode_ready, 0);
        mode_pin = post[0];
        step();
        alloc_valid = 0; flush_req = 0;
        check("R1 ready high after second edge", mode_ready, 1);
        check("R1 latched mode", mode_wb, exp_wb);
        clear_model();
        if (poke) check_array("R2 inputs ignored before ready");
    endtask

    task automatic alloc(int idx, bit pol);
        alloc_valid = 1; alloc_idx = 4'(idx); alloc_wb = pol;
        step();
        alloc_valid = 0;
        exp_st[idx] = (mode_wb && pol) ? 2'b10 : 2'b01;
    endtask

    task automatic hit(int idx);
        wr_hit_valid = 1; wr_hit_idx = 4'(idx);
        step();
        wr_hit_valid = 0;
        if (exp_st[idx] == 2'b10) exp_st[idx] = 2'b11;
    endtask

    // Write-back flush with a delaying bus responder; optional injection
    // of a new flush and an allocation at the first request (R11).
    task automatic run_walk(bit inject, string tag);
        int exp_list [LINES];
        int n_exp = 0, exp_k = LINES, nreq = 0, nack = 0, ack_k = -1, waited = 0;
        bit pending = 0, injected = 0;
        for (int i = 0; i < LINES; i++)
            if (exp_st[i] == 2'b11) begin
                exp_list[n_exp] = i; n_exp++; exp_k += (i % 3) + 1;
            end
        flush_req = 1;
        step();
        flush_req = 0;
        for (int k = 1; k < 400; k++) begin
            step();
            flush_req = 0; alloc_valid = 0;
            if (flush_ack_cycle) begin
                nack++;
                if (nack == 1) ack_k = k;
            end
            if (wb_ack) begin
                wb_ack = 0; pending = 0;
            end else if (wb_req) begin
                if (!pending) begin
                    pending = 1; waited = 0;
                    check({tag, " R9 write-back order"}, wb_idx,
                          (nreq < n_exp) ? exp_list[nreq] : -1);
                    nreq++;
                    if (inject && !injected) begin
                        injected = 1; flush_req = 1;
                        alloc_valid = 1; alloc_idx = 0; alloc_wb = 1;
                    end
                end
                if (waited == int'(wb_idx) % 3) wb_ack = 1;
                else waited++;
            end
            if (ack_k >= 0 && k >= ack_k + 4) break;
        end
        clear_model();
        check({tag, " R9 write-back count"}, nreq, n_exp);
        check({tag, " R10 single ack pulse"}, nack, 1);
        check({tag, " R10 ack edge"}, ack_k, exp_k);
        check({tag, " R11 no second walk"}, flush_busy, 0);
        check_array({tag, " R9 R11 array empty after walk"});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        // R1 R3: sweep every window combination
        for (int m = 0; m < 16; m++) begin
            do_reset(1'b1, 2'(m >> 2), 2'(m), m == 5);
            mode_pin = ~mode_pin; step();
            mode_pin = ~mode_pin; soft_rst = 1; step(); soft_rst = 0; step();
            check("R3 mode unchanged", mode_wb, m == 15);
        end
        do_reset(1'b0, 2'b11, 2'b11, 1'b0);
        check("R1 early low samples do not matter", mode_wb, 1);

        // Write-through mode
        do_reset(1'b1, 2'b01, 2'b11, 1'b0);
        check_array("R4 reset state");
        for (int i = 0; i < LINES; i++) alloc(i, i[0]);
        check_array("R5 write-through alloc always Shared");
        for (int i = 0; i < LINES; i += 2) hit(i);
        check_array("R6 write hit on Shared keeps it");
        inv_valid = 1; inv_idx = 3; step(); inv_valid = 0;
        check_array("R7 invalidate ignored in write-through");
        lock_req = 1; #0.2;
        check("R12 lock passes in write-through", bus_lock, 1);
        lock_req = 0; #0.2;
        check("R12 lock idle", bus_lock, 0);
        flush_req = 1; step(); flush_req = 0;
        check("R8 no write-back request", wb_req, 0);
        check("R8 no ack cycle", flush_ack_cycle, 0);
        clear_model();
        check_array("R8 one-edge clear");
        alloc(2, 1); alloc(9, 0);
        check_array("R5 realloc");
        soft_rst = 1; step(); soft_rst = 0;
        clear_model();
        check_array("R13 soft reset clears in write-through");
        check("R13 mode kept", mode_wb, 0);

        // Write-back mode
        do_reset(1'b0, 2'b11, 2'b11, 1'b0);
        lock_req = 1; #0.2;
        check("R12 lock held low in write-back", bus_lock, 0);
        lock_req = 0;
        for (int i = 0; i < LINES; i++) alloc(i, (i % 3) != 0);
        check_array("R5 write-back policy tagging");
        for (int i = 0; i < LINES; i += 2) hit(i);
        check_array("R6 Exclusive to Modified");
        inv_valid = 1; inv_idx = 1; step(); inv_valid = 0;
        exp_st[1] = 2'b00;
        check_array("R7 invalidate in write-back");
        soft_rst = 1; step(); soft_rst = 0;
        check_array("R13 soft reset no effect in write-back");
        check("R13 mode kept", mode_wb, 1);
        run_walk(1'b1, "walk mixed");
        run_walk(1'b0, "walk empty");
        alloc(0, 0); alloc(15, 1); hit(15);
        check_array("R6 last line Modified");
        run_walk(1'b0, "walk last line");
        alloc(4, 1); hit(4); alloc(5, 1); hit(5); alloc(6, 1);
        run_walk(1'b0, "walk adjacent");

        summary();
    end
endmodule